// File: doc/BRIEF.md
# PCI Configuration Address Port

This block is the software-facing side of an indirect configuration mechanism for a PCI host. Software first writes a 32-bit selector word into an address register at offset 0. It then reads or writes a data port at offset 4, and that access is steered to the configuration word the selector names. The block keeps the selector and cleans up every value written to it. It splits the selector into bus, device, function and register fields, and it forwards data-port accesses to a small internal array of configuration words. That array stands in for real targets on a PCI bus.

A bridge register window starts at offset 0x80000 and is 0xFF bytes long. Inside it sits one general status word at window offset 0xE0. Software can write every bit of it, and it reads back as written. All accesses use a simple one-request-per-cycle register interface with little-endian byte lanes. Read data comes back one cycle after the request.

Top module: `cfg_addr_port`

## Requirements
- R1: After reset the address register, the status word and every configuration word read as 0, and rsp_valid is low.
- R2: The address register is written only by a write with req_addr exactly 0 and req_size = 2 (four bytes). Any other size, or any other address inside the word at offset 0, leaves it unchanged.
- R3: An accepted address write stores req_wdata with bits 1:0 forced to 0 and bit 31 forced to 1.
- R4: A read at any byte of the word at offset 0 returns the stored address register unchanged, all 32 bits, whatever the size.
- R5: The outputs sel_bus, sel_dev, sel_func and sel_reg always show address register bits 23:16, 15:11, 10:8 and 7:2.
- R6: A target is present when bus = 0, function = 0 and device < NUM_DEV (default 2). A data-port write (word at offset 4) to a present target updates the enabled byte lanes of configuration word sel_reg of device sel_dev. A data-port read returns that whole word.
- R7: A data-port read with no present target returns 0xFFFFFFFF. A data-port write with no present target changes no configuration word.
- R8: The status word at offset 0x800E0 resets to 0, takes writes on its enabled byte lanes and reads back whole.
- R9: Byte lanes follow req_size: 0 is one byte, 1 is two bytes, 2 is four bytes, and 3 writes nothing. The lanes start at byte req_addr[1:0], and any lane past byte 3 is dropped. Write data sits on its natural little-endian lane (byte k on req_wdata[8k+7:8k]).
- R10: A read request gives rsp_valid high on the next cycle, with rsp_rdata holding the word. A write gives no response. Reads of unmapped addresses return 0.
- R11: Writes to unmapped addresses change no state that can be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address |
| req_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 none |
| req_wdata | input | 32 | Write data on natural byte lanes |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| sel_bus | output | 8 | Decoded bus number |
| sel_dev | output | 5 | Decoded device number |
| sel_func | output | 3 | Decoded function number |
| sel_reg | output | 6 | Decoded register word index |

## Verification
The bench sends narrow and unaligned writes to the address register. A design that accepted them would corrupt the selector, and the next read-back would show it. Selector values with bit 31 clear and the low bits set test the clean-up. A design that passed them through would read back the raw value. Data-port writes to device numbers at and above the present count, and to nonzero bus or function, test the absent-target case. A design that truncated the device index would alias those writes onto device 0. A design that did not float absent reads high would return stale words. Half-word accesses at byte offset 3 test the lane clipping. A design that wrapped lanes would corrupt byte 0 of the status word or of a configuration word.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } size_e;

  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FUNC_W = 3;
  localparam int REG_W  = 6;

  typedef struct packed {
    logic [BUS_W-1:0]  bus;
    logic [DEV_W-1:0]  dev;
    logic [FUNC_W-1:0] func;
    logic [REG_W-1:0]  regn;
  } cfg_sel_t;

  // Clean a selector value: enable forced on, low two bits dropped.
  function automatic logic [31:0] sanitize_sel(input logic [31:0] raw);
    return {1'b1, raw[30:2], 2'b00};
  endfunction

  // Byte-lane enables for a size code starting at byte offset off.
  function automatic logic [3:0] lane_mask(input size_e sz, input logic [1:0] off);
    logic [7:0] w;
    case (sz)
      SZ_BYTE: w = 8'h01;
      SZ_HALF: w = 8'h03;
      SZ_WORD: w = 8'h0F;
      default: w = 8'h00;
    endcase
    w = w << off;
    return w[3:0];
  endfunction

  // Replace enabled bytes of old_w with the bytes of new_w.
  function automatic logic [31:0] merge_lanes(input logic [31:0] old_w,
                                              input logic [31:0] new_w,
                                              input logic [3:0]  mask);
    logic [31:0] r;
    r = old_w;
    for (int b = 0; b < 4; b++) begin
      if (mask[b]) r[8*b +: 8] = new_w[8*b +: 8];
    end
    return r;
  endfunction

  // Split a selector word into its fields.
  function automatic cfg_sel_t decode_sel(input logic [31:0] a);
    cfg_sel_t s;
    s.bus  = a[23:16];
    s.dev  = a[15:11];
    s.func = a[10:8];
    s.regn = a[7:2];
    return s;
  endfunction

endpackage

// File: rtl/cfg_sel_reg.sv
module cfg_sel_reg
  import cfg_port_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              wr_ok,
  output logic [31:0]       sel_q
);

  assign wr_ok = req_valid && req_write && (req_addr == '0) &&
                 (size_e'(req_size) == SZ_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (wr_ok) begin
      sel_q <= sanitize_sel(req_wdata);
    end
  end

endmodule

// File: rtl/cfg_target_array.sv
module cfg_target_array
  import cfg_port_pkg::*;
#(
  parameter int NUM_DEV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  cfg_sel_t    sel,
  input  logic [3:0]  mask,
  input  logic [31:0] wdata,
  output logic        present,
  output logic [31:0] rdata
);

  localparam int WORDS = 1 << REG_W;
  localparam int DEPTH = NUM_DEV * WORDS;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [31:0]      mem [DEPTH];
  logic [IDX_W-1:0] idx;

  assign present = (sel.bus == '0) && (sel.func == '0) &&
                   (32'(sel.dev) < NUM_DEV);
  assign idx     = IDX_W'(32'(sel.dev) * WORDS + 32'(sel.regn));
  assign rdata   = present ? mem[idx] : 32'hFFFF_FFFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && present) begin
      mem[idx] <= merge_lanes(mem[idx], wdata, mask);
    end
  end

endmodule

// File: rtl/bridge_status.sv
module bridge_status
  import cfg_port_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  mask,
  input  logic [31:0] wdata,
  output logic [31:0] status_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (wr_en) begin
      status_q <= merge_lanes(status_q, wdata, mask);
    end
  end

endmodule

// File: rtl/cfg_addr_port.sv
module cfg_addr_port
  import cfg_port_pkg::*;
#(
  parameter int              ADDR_W      = 20,
  parameter int              NUM_DEV     = 2,
  parameter logic [ADDR_W-1:0] BRIDGE_BASE = 20'h80000,
  parameter int              STS_OFF     = 'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [7:0]        sel_bus,
  output logic [4:0]        sel_dev,
  output logic [2:0]        sel_func,
  output logic [5:0]        sel_reg
);

  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] SEL_WORD  = WORD_W'(0);
  localparam logic [WORD_W-1:0] DATA_WORD = WORD_W'(1);
  localparam logic [WORD_W-1:0] STS_WORD  =
    WORD_W'((32'(BRIDGE_BASE) + STS_OFF) >> 2);

  logic [WORD_W-1:0] word;
  logic [3:0]        mask;
  logic              addr_wr_ok;
  logic [31:0]       sel_q;
  cfg_sel_t          sel;
  logic              tgt_present;
  logic [31:0]       tgt_rdata;
  logic              dp_wr;
  logic              sts_wr;
  logic [31:0]       status_q;
  logic              rd_req;
  logic              dp_miss_rd;
  logic [31:0]       rd_mux;

  assign word   = req_addr[ADDR_W-1:2];
  assign mask   = lane_mask(size_e'(req_size), req_addr[1:0]);
  assign rd_req = req_valid && !req_write;
  assign dp_wr  = req_valid && req_write && (word == DATA_WORD);
  assign sts_wr = req_valid && req_write && (word == STS_WORD);

  cfg_sel_reg #(.ADDR_W(ADDR_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .wr_ok     (addr_wr_ok),
    .sel_q     (sel_q)
  );

  assign sel      = decode_sel(sel_q);
  assign sel_bus  = sel.bus;
  assign sel_dev  = sel.dev;
  assign sel_func = sel.func;
  assign sel_reg  = sel.regn;

  cfg_target_array #(.NUM_DEV(NUM_DEV)) u_tgt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (dp_wr),
    .sel     (sel),
    .mask    (mask),
    .wdata   (req_wdata),
    .present (tgt_present),
    .rdata   (tgt_rdata)
  );

  bridge_status u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (sts_wr),
    .mask     (mask),
    .wdata    (req_wdata),
    .status_q (status_q)
  );

  assign dp_miss_rd = rd_req && (word == DATA_WORD) && !tgt_present;

  always_comb begin
    if (word == SEL_WORD)       rd_mux = sel_q;
    else if (word == DATA_WORD) rd_mux = tgt_rdata;
    else if (word == STS_WORD)  rd_mux = status_q;
    else                        rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/cfg_addr_port_chk.sv
module cfg_addr_port_chk #(
  parameter int ADDR_W = 20,
  parameter int STS_W  = 'h20038
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic [31:0]       sel_q,
  input logic [31:0]       status_q,
  input logic              dp_miss_rd
);

  // R3
  sel_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != 32'd0) |-> (sel_q[31] && (sel_q[1:0] == 2'b00)));

  // R2
  sel_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && (req_addr[ADDR_W-1:2] == '0) &&
     !((req_addr[1:0] == 2'b00) && (req_size == 2'd2))) |=> $stable(sel_q));

  // R10
  rsp_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R10
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R7
  absent_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_miss_rd |=> (rsp_rdata == 32'hFFFF_FFFF));

  // R11
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && (32'(req_addr[ADDR_W-1:2]) == STS_W)) |=> $stable(status_q));

endmodule

bind cfg_addr_port cfg_addr_port_chk #(
  .ADDR_W (ADDR_W),
  .STS_W  ((32'(BRIDGE_BASE) + STS_OFF) >> 2)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_size   (req_size),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .sel_q      (sel_q),
  .status_q   (status_q),
  .dp_miss_rd (dp_miss_rd)
);

// File: tb/cfg_addr_port_tb.sv
module cfg_addr_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [7:0]  sel_bus;
  logic [4:0]  sel_dev;
  logic [2:0]  sel_func;
  logic [5:0]  sel_reg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_sel;
  logic [31:0] m_sts;
  logic [31:0] m_cfg [2][64];

  localparam logic [19:0] STS_ADDR = 20'h800E0;

  always #4 clk = ~clk;

  cfg_addr_port u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sel_bus(sel_bus),
    .sel_dev(sel_dev), .sel_func(sel_func), .sel_reg(sel_reg)
  );

  function automatic logic [31:0] put_bytes(logic [31:0] old_w, logic [31:0] new_w,
                                            logic [1:0] sz, logic [1:0] off);
    int n;
    logic [31:0] r;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
    r = old_w;
    for (int b = 0; b < 4; b++)
      if (b >= off && b < off + n) r[8*b +: 8] = new_w[8*b +: 8];
    return r;
  endfunction

  function automatic bit tgt_here(logic [31:0] s);
    return (s[23:16] == 8'd0) && (s[10:8] == 3'd0) && (s[15:11] < 5'd2);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [19:0] a, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_size = sz; req_wdata = d;
    if (a == 20'd0 && sz == 2'd2) m_sel = {1'b1, d[30:2], 2'b00};
    else if (a[19:2] == 18'd1) begin
      if (tgt_here(m_sel))
        m_cfg[m_sel[11]][m_sel[7:2]] =
          put_bytes(m_cfg[m_sel[11]][m_sel[7:2]], d, sz, a[1:0]);
    end else if (a[19:2] == STS_ADDR[19:2]) m_sts = put_bytes(m_sts, d, sz, a[1:0]);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  function automatic logic [31:0] expect_rd(logic [19:0] a);
    if (a[19:2] == 18'd0) return m_sel;
    if (a[19:2] == 18'd1)
      return tgt_here(m_sel) ? m_cfg[m_sel[11]][m_sel[7:2]] : 32'hFFFF_FFFF;
    if (a[19:2] == STS_ADDR[19:2]) return m_sts;
    return 32'd0;
  endfunction

  task automatic rd(logic [19:0] a, logic [1:0] sz, string req);
    logic [31:0] e;
    e = expect_rd(a);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 0;
    check({req, " R10 valid"}, 32'(rsp_valid), 32'd1);
    check(req, rsp_rdata, e);
  endtask

  task automatic check_fields(string tag);
    check({tag, " R5 fields"}, {8'd0, sel_bus, sel_dev, sel_func, sel_reg, 2'd0},
          {8'd0, m_sel[23:2], 2'd0});
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_sel = 0; m_sts = 0;
    for (int d = 0; d < 2; d++) for (int r = 0; r < 64; r++) m_cfg[d][r] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    rd(20'd0, 2'd2, "R1 sel reset");
    rd(STS_ADDR, 2'd2, "R1 status reset");
    wr(20'd0, 2'd2, 32'h0000_0814);
    rd(20'd4, 2'd2, "R1 cfg reset");
    // R3 sanitising
    wr(20'd0, 2'd2, 32'h0000_0003);
    rd(20'd0, 2'd2, "R3 low bits set, enable clear");
    check_fields("R3");
    // R2 rejected writes
    wr(20'd0, 2'd0, 32'hFFFF_FFFF);
    rd(20'd0, 2'd2, "R2 byte write ignored");
    wr(20'd2, 2'd1, 32'hABCD_0000);
    rd(20'd0, 2'd2, "R2 offset 2 ignored");
    wr(20'd1, 2'd2, 32'h1234_5678);
    rd(20'd3, 2'd0, "R4 R2 offset 1 ignored, byte read");
    // R6 present target, R9 lanes
    wr(20'd0, 2'd2, 32'h0000_0810);
    check_fields("R6");
    wr(20'd4, 2'd2, 32'h1122_3344);
    wr(20'd7, 2'd1, 32'hAA00_0000);
    rd(20'd4, 2'd2, "R6 R9 half at offset 3 clipped");
    // R7 absent device aliasing test
    wr(20'd0, 2'd2, 32'h0000_1010);
    wr(20'd4, 2'd2, 32'hDEAD_BEEF);
    rd(20'd4, 2'd2, "R7 absent dev read");
    wr(20'd0, 2'd2, 32'h0001_0010);
    wr(20'd4, 2'd2, 32'hDEAD_BEEF);
    rd(20'd5, 2'd0, "R7 absent bus read");
    wr(20'd0, 2'd2, 32'h0000_0110);
    rd(20'd4, 2'd2, "R7 absent func read");
    wr(20'd0, 2'd2, 32'h0000_0010);
    rd(20'd4, 2'd2, "R7 dev0 untouched");
    // R8 status lanes
    wr(STS_ADDR, 2'd2, 32'hCAFE_F00D);
    wr(STS_ADDR + 20'd3, 2'd1, 32'h5500_0000);
    rd(STS_ADDR, 2'd2, "R8 R9 status clip");
    wr(STS_ADDR + 20'd1, 2'd3, 32'hFFFF_FFFF);
    rd(STS_ADDR + 20'd2, 2'd1, "R9 size 3 no write");
    // R11 unmapped
    wr(20'h00100, 2'd2, 32'h7777_7777);
    wr(20'h800E4, 2'd2, 32'h7777_7777);
    rd(20'h00100, 2'd2, "R10 R11 unmapped reads zero");
    rd(STS_ADDR, 2'd2, "R11 status unchanged");
    rd(20'd0, 2'd2, "R11 selector unchanged");
    // random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [31:0] v;
      op = int'($urandom_range(0, 9));
      v = $urandom;
      case (op)
        0, 1: begin
          v[23:16] = ($urandom_range(0, 7) == 0) ? v[23:16] : 8'd0;
          v[10:8]  = ($urandom_range(0, 7) == 0) ? v[10:8] : 3'd0;
          v[15:11] = 5'($urandom_range(0, 3));
          wr(20'd0, 2'($urandom_range(0, 3)) | 2'd2 & 2'($urandom_range(0,3)), v);
          check_fields("R5 random");
        end
        2, 3, 4: wr(20'd4 + 20'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), v);
        5: wr(STS_ADDR + 20'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), v);
        6: rd(20'd0 + 20'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), "R4 random");
        7, 8: rd(20'd4 + 20'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), "R6 R7 random");
        default: rd(STS_ADDR, 2'd2, "R8 random");
      endcase
    end
    done = 1;
    summary();
  end

endmodule